// File: doc/BRIEF.md
# Trigger-Driven Multiplexed Analog Readout Sequencer

This block controls the readout of a chain of 64-channel front-end chips. The chips share one multiplexed analog output line. A rising edge on the trigger input starts a fixed sequence. The block waits a programmable number of cycles for the shapers to peak, then raises a hold line that freezes every shaper output. It then passes a start token into the first chip and steps a divided readout clock through all channels of all chained chips. For each channel it fires one conversion request to a 12-bit ADC a set number of system cycles after the readout clock edge, so the analog line has time to settle.

Each conversion result leaves the block on a valid-qualified stream. A beat carries the channel index, the 12-bit sample and a flag that marks the final channel. The busy line covers the whole window from trigger acceptance to hold release, and so equals the dead time. A trigger edge that arrives during that window does not start a readout. It advances a saturating counter of lost triggers instead.

Top module: `ro_readout_seq`

## Requirements
- R1: After reset, busy, hold, readout clock, shift token, convert request and stream valid are all 0, and the lost-trigger count is 0.
- R2: A rising edge on the trigger while idle raises busy on the following cycle. Hold rises exactly HOLD_DLY cycles after busy rises.
- R3: The readout clock toggles only while hold is high. Each high phase lasts exactly HALF_DIV system cycles, and each low phase lasts at least HALF_DIV cycles, so the readout clock never runs faster than system clock / (2*HALF_DIV).
- R4: The shift token is high for the whole first channel slot and for no other slot.
- R5: Each channel gets exactly one convert request. It is a one-cycle pulse issued SETTLE cycles after that slot's readout clock rising edge, and only while hold is high.
- R6: The ADC returns a result with a one-cycle done pulse. The cycle after that pulse, the stream shows valid with the channel index and the data. Indices run 0 to NCH-1 in order, where NCH = chips x 64.
- R7: The last flag is 1 on the beat for channel NCH-1 and 0 on every other beat.
- R8: A slot lasts max(2*HALF_DIV, SETTLE+D+1) cycles, where D is the ADC latency in cycles from request to done. A slow ADC stretches the low phase of the readout clock.
- R9: Hold and busy fall together at the end of the last slot, after the last result has been taken. Busy stays high for HOLD_DLY + NCH x slot cycles.
- R10: A trigger edge while busy does not change the running readout. It adds one to the lost-trigger count, which stops at 2^LOST_W-1.
- R11: With the default parameters and an ADC latency of up to 10 cycles, busy lasts no more than 2000 cycles (20 us at 100 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | External trigger; its rising edge is the event |
| busy_o | output | 1 | Dead-time window |
| hold_o | output | 1 | Freezes the shaper outputs |
| ro_clk_o | output | 1 | Divided readout clock to the chips |
| shift_in_o | output | 1 | Start token into the first chip |
| adc_start_o | output | 1 | One-cycle convert request |
| adc_done_i | input | 1 | One-cycle conversion done |
| adc_data_i | input | 12 | Conversion result, valid with done |
| out_valid_o | output | 1 | Stream beat valid |
| out_chan_o | output | CH_W | Channel index of the beat |
| out_data_o | output | 12 | Sample of the beat |
| out_last_o | output | 1 | Beat belongs to the final channel |
| lost_cnt_o | output | LOST_W | Saturating count of ignored triggers |

## Verification
Every result has a fixed latency, and the bench samples all outputs on the falling edge. Busy is seen one falling edge after the trigger edge is taken, and hold is seen HOLD_DLY falling edges after that. A convert request appears SETTLE samples after the falling edge on which the readout clock was first seen high. A stream beat appears one sample after the done pulse. The bench's ADC model answers D cycles after it sees a request. From the requirements alone, the bench works out the slot length max(10, SETTLE+D+1) and the expected busy length. It compares the counted cycles of busy, hold and shift token, and the order of the stream beats, against those figures.

// File: rtl/ro_seq_pkg.sv
package ro_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEAK = 2'd1,
    ST_SCAN = 2'd2
  } seq_state_t;

  // saturating increment for an up-counter of width W
  function automatic logic [15:0] sat_inc(input logic [15:0] val, input logic [15:0] top);
    return (val >= top) ? top : val + 16'd1;
  endfunction

  // one channel slot in system cycles for a given ADC latency
  function automatic int unsigned slot_len(input int unsigned half_div,
                                           input int unsigned settle,
                                           input int unsigned latency);
    int unsigned base;
    base = 2 * half_div;
    return (settle + latency + 1 > base) ? settle + latency + 1 : base;
  endfunction

endpackage

// File: rtl/ro_phase_gen.sv
module ro_phase_gen #(
  parameter int HALF_DIV = 5,
  parameter int SETTLE   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic got_now_i,
  output logic ro_clk_o,
  output logic conv_fire_o,
  output logic slot_end_o
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int PH_W   = $clog2(PERIOD);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0] PH_HALF  = PH_W'(HALF_DIV);
  localparam logic [PH_W-1:0] PH_CONV  = PH_W'(SETTLE);

  logic [PH_W-1:0] ph;

  assign slot_end_o  = run_i && (ph == PH_LAST);
  assign conv_fire_o = run_i && (ph == PH_CONV);
  assign ro_clk_o    = run_i && (ph < PH_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (!run_i) begin
      ph <= '0;
    end else if (ph == PH_LAST) begin
      if (got_now_i) ph <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end
endmodule

// File: rtl/ro_chan_ctr.sv
module ro_chan_ctr #(
  parameter int NCH = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_i,
  input  logic                     step_i,
  output logic [$clog2(NCH)-1:0]   chan_o,
  output logic                     first_o,
  output logic                     last_o
);
  localparam int CH_W = $clog2(NCH);
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);

  logic [CH_W-1:0] chan;

  assign chan_o  = chan;
  assign first_o = run_i && (chan == '0);
  assign last_o  = (chan == CH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan <= '0;
    end else if (!run_i) begin
      chan <= '0;
    end else if (step_i && !last_o) begin
      chan <= chan + 1'b1;
    end
  end
endmodule

// File: rtl/ro_capture.sv
module ro_capture #(
  parameter int CH_W     = 7,
  parameter int ADC_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                step_i,
  input  logic                adc_done_i,
  input  logic [ADC_BITS-1:0] adc_data_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic                last_i,
  output logic                got_now_o,
  output logic                out_valid_o,
  output logic [CH_W-1:0]     out_chan_o,
  output logic [ADC_BITS-1:0] out_data_o,
  output logic                out_last_o
);
  logic got;
  logic take;

  assign take      = run_i && adc_done_i && !got;
  assign got_now_o = got || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got <= 1'b0;
    end else if (!run_i || step_i) begin
      got <= 1'b0;
    end else if (take) begin
      got <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_chan_o  <= '0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else begin
      out_valid_o <= take;
      if (take) begin
        out_chan_o <= chan_i;
        out_data_o <= adc_data_i;
        out_last_o <= last_i;
      end else begin
        out_last_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ro_lost_ctr.sv
module ro_lost_ctr
  import ro_seq_pkg::*;
#(
  parameter int LOST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  output logic [LOST_W-1:0] cnt_o
);
  localparam logic [15:0] TOP = 16'((1 << LOST_W) - 1);

  logic [15:0] nxt;

  assign nxt = sat_inc(16'(cnt_o), TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else if (inc_i) cnt_o <= nxt[LOST_W-1:0];
  end
endmodule

// File: rtl/ro_readout_seq.sv
module ro_readout_seq
  import ro_seq_pkg::*;
#(
  parameter int N_CHIPS     = 2,
  parameter int CH_PER_CHIP = 64,
  parameter int ADC_BITS    = 12,
  parameter int HALF_DIV    = 5,
  parameter int SETTLE      = 3,
  parameter int HOLD_DLY    = 6,
  parameter int LOST_W      = 4,
  localparam int NCH        = N_CHIPS * CH_PER_CHIP,
  localparam int CH_W       = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_i,
  output logic                busy_o,
  output logic                hold_o,
  output logic                ro_clk_o,
  output logic                shift_in_o,
  output logic                adc_start_o,
  input  logic                adc_done_i,
  input  logic [ADC_BITS-1:0] adc_data_i,
  output logic                out_valid_o,
  output logic [CH_W-1:0]     out_chan_o,
  output logic [ADC_BITS-1:0] out_data_o,
  output logic                out_last_o,
  output logic [LOST_W-1:0]   lost_cnt_o
);
  localparam int PK_W = $clog2(HOLD_DLY + 1);
  localparam logic [PK_W-1:0] PK_LAST = PK_W'(HOLD_DLY - 1);

  seq_state_t state;
  logic [PK_W-1:0] pk;
  logic trig_q;

  // named internal events
  logic ev_trig, ev_accept, ev_lost, ev_step, ev_finish;
  logic run, slot_end, got_now, first_slot, last_chan;
  logic [CH_W-1:0] chan;

  assign run       = (state == ST_SCAN);
  assign ev_trig   = trig_i && !trig_q;
  assign ev_accept = ev_trig && (state == ST_IDLE);
  assign ev_lost   = ev_trig && (state != ST_IDLE);
  assign ev_step   = slot_end && got_now;
  assign ev_finish = ev_step && last_chan;

  assign busy_o     = (state != ST_IDLE);
  assign hold_o     = run;
  assign shift_in_o = first_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pk    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          pk <= '0;
          if (ev_accept) state <= ST_PEAK;
        end
        ST_PEAK: begin
          if (pk == PK_LAST) begin
            state <= ST_SCAN;
            pk    <= '0;
          end else begin
            pk <= pk + 1'b1;
          end
        end
        ST_SCAN: begin
          if (ev_finish) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  ro_phase_gen #(.HALF_DIV(HALF_DIV), .SETTLE(SETTLE)) u_phase (
    .clk(clk), .rst_n(rst_n), .run_i(run), .got_now_i(got_now),
    .ro_clk_o(ro_clk_o), .conv_fire_o(adc_start_o), .slot_end_o(slot_end)
  );

  ro_chan_ctr #(.NCH(NCH)) u_chan (
    .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(ev_step),
    .chan_o(chan), .first_o(first_slot), .last_o(last_chan)
  );

  ro_capture #(.CH_W(CH_W), .ADC_BITS(ADC_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(ev_step),
    .adc_done_i(adc_done_i), .adc_data_i(adc_data_i),
    .chan_i(chan), .last_i(last_chan), .got_now_o(got_now),
    .out_valid_o(out_valid_o), .out_chan_o(out_chan_o),
    .out_data_o(out_data_o), .out_last_o(out_last_o)
  );

  ro_lost_ctr #(.LOST_W(LOST_W)) u_lost (
    .clk(clk), .rst_n(rst_n), .inc_i(ev_lost), .cnt_o(lost_cnt_o)
  );
endmodule

// File: rtl/ro_readout_seq_chk.sv
module ro_readout_seq_chk #(
  parameter int CH_W     = 7,
  parameter int NCH      = 128,
  parameter int LOST_W   = 4,
  parameter int MAX_DEAD = 2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              hold,
  input logic              ro_clk,
  input logic              shift_in,
  input logic              adc_start,
  input logic              out_valid,
  input logic              out_last,
  input logic [CH_W-1:0]   out_chan,
  input logic [LOST_W-1:0] lost_cnt,
  input logic              ev_accept,
  input logic              ev_lost,
  input logic              ev_finish
);
  localparam logic [LOST_W-1:0] LOST_TOP = {LOST_W{1'b1}};
  logic [15:0] dead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dead <= '0;
    else if (busy) dead <= (dead == 16'hFFFF) ? dead : dead + 16'd1;
    else           dead <= '0;
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy && !hold);
  assert_hold_from_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(busy));
  assert_roclk_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ro_clk |-> hold);
  assert_shift_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_in |-> hold);
  assert_start_in_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> hold);
  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  assert_last_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_chan == CH_W'(NCH - 1));
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> !hold && !busy);
  assert_fall_together_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> !busy);
  assert_lost_inc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lost && lost_cnt != LOST_TOP |=> lost_cnt == $past(lost_cnt) + 1'b1);
  assert_lost_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lost_cnt == LOST_TOP |=> lost_cnt == LOST_TOP);
  assert_dead_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dead <= 16'(MAX_DEAD));
endmodule

bind ro_readout_seq ro_readout_seq_chk #(
  .CH_W(CH_W), .NCH(NCH), .LOST_W(LOST_W), .MAX_DEAD(2000)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .hold(hold_o), .ro_clk(ro_clk_o),
  .shift_in(shift_in_o), .adc_start(adc_start_o), .out_valid(out_valid_o),
  .out_last(out_last_o), .out_chan(out_chan_o), .lost_cnt(lost_cnt_o),
  .ev_accept(ev_accept), .ev_lost(ev_lost), .ev_finish(ev_finish)
);

// File: tb/test_ro_readout_seq.sv
module test_ro_readout_seq;
  localparam int NCH      = 128;
  localparam int HALF     = 5;
  localparam int SETTLE   = 3;
  localparam int HOLD_DLY = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic busy, hold, ro_clk, shift_in, adc_start, out_valid, out_last;
  logic adc_done = 1'b0;
  logic [11:0] adc_data = '0;
  logic [6:0] out_chan;
  logic [11:0] out_data;
  logic [3:0] lost_cnt;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  ro_readout_seq i_ro_readout_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .busy_o(busy), .hold_o(hold),
    .ro_clk_o(ro_clk), .shift_in_o(shift_in), .adc_start_o(adc_start),
    .adc_done_i(adc_done), .adc_data_i(adc_data), .out_valid_o(out_valid),
    .out_chan_o(out_chan), .out_data_o(out_data), .out_last_o(out_last),
    .lost_cnt_o(lost_cnt)
  );

  function automatic logic [11:0] pat(input int i);
    return 12'((i * 157 + 91) % 4096);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ADC model
  int adc_lat = 2, adc_cd = 0, adc_req = 0;
  always @(negedge clk) begin
    adc_done <= 1'b0;
    if (adc_start) begin
      adc_cd = adc_lat;
    end else if (adc_cd > 0) begin
      adc_cd--;
      if (adc_cd == 0) begin
        adc_done <= 1'b1;
        adc_data <= pat(adc_req);
        adc_req++;
      end
    end
  end

  // monitor
  int cyc = 0;
  bit p_ro = 0, p_hold = 0, p_busy = 0;
  int hi_run, lo_run, since, rises, starts, start_bad, hi_bad, lo_bad;
  int shift_cyc, shift_bad, busy_cyc, busy_rise, hold_rise, outs, out_bad, lasts, fall_bad;

  task automatic clear_stats();
    hi_run = 0; lo_run = 0; since = 0; rises = 0; starts = 0; start_bad = 0;
    hi_bad = 0; lo_bad = 0; shift_cyc = 0; shift_bad = 0; busy_cyc = 0;
    busy_rise = -1; hold_rise = -1; outs = 0; out_bad = 0; lasts = 0; fall_bad = 0;
    adc_req = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (out_valid) begin
      if (out_chan != 7'(outs) || out_data != pat(outs) || out_last != (outs == NCH - 1))
        out_bad++;
      if (out_last) lasts++;
      outs++;
    end
    if (ro_clk) begin
      if (!p_ro) begin
        rises++; since = 0;
        if (lo_run > 0 && lo_run < HALF) lo_bad++;
        lo_run = 0;
        if (rises >= 2 && shift_in) shift_bad++;
      end else since++;
      hi_run++;
    end else begin
      if (hi_run > 0 && hi_run != HALF) hi_bad++;
      hi_run = 0;
      if (hold) lo_run++;
      since++;
    end
    if (adc_start) begin
      starts++;
      if (since != SETTLE || !hold) start_bad++;
    end
    if (shift_in) shift_cyc++;
    if (busy) busy_cyc++;
    if (busy && !p_busy) busy_rise = cyc;
    if (hold && !p_hold) hold_rise = cyc;
    if (p_hold && !hold && (busy || outs != NCH)) fall_bad++;
    p_ro = ro_clk; p_hold = hold; p_busy = busy;
  end

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  // one readout with ADC latency lat and n_extra triggers during busy
  task automatic run_case(input int lat, input int n_extra, input int lost_exp, input string tag);
    int slot, t;
    adc_lat = lat;
    clear_stats();
    slot = 2 * HALF;
    if (SETTLE + lat + 1 > slot) slot = SETTLE + lat + 1;
    pulse_trig();
    repeat (20) @(negedge clk);
    for (int k = 0; k < n_extra; k++) begin
      pulse_trig();
      repeat (3) @(negedge clk);
    end
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    $display("case %s slot=%0d", tag, slot);
    check(hold_rise - busy_rise == HOLD_DLY, "R2 hold delay", hold_rise - busy_rise, HOLD_DLY);
    check(hi_bad == 0, "R3 high phase", hi_bad, 0);
    check(lo_bad == 0, "R3 low phase", lo_bad, 0);
    check(rises == NCH, "R3 clock count", rises, NCH);
    check(shift_cyc == slot && shift_bad == 0, "R4 shift token", shift_cyc, slot);
    check(starts == NCH, "R5 request count", starts, NCH);
    check(start_bad == 0, "R5 request timing", start_bad, 0);
    check(outs == NCH && out_bad == 0, "R6 stream", out_bad, 0);
    check(lasts == 1, "R7 last flag", lasts, 1);
    check(busy_cyc == HOLD_DLY + NCH * slot, "R8 R9 busy length", busy_cyc, HOLD_DLY + NCH * slot);
    check(fall_bad == 0, "R9 release", fall_bad, 0);
    check(busy_cyc <= 2000, "R11 dead time", busy_cyc, 2000);
    check(int'(lost_cnt) == lost_exp, "R10 lost count", int'(lost_cnt), lost_exp);
  endtask

  task automatic test_reset();
    check(!busy && !hold, "R1 busy/hold", {busy, hold}, 0);
    check(!ro_clk && !shift_in, "R1 clk/token", {ro_clk, shift_in}, 0);
    check(!adc_start && !out_valid, "R1 start/valid", {adc_start, out_valid}, 0);
    check(lost_cnt == 0, "R1 lost", int'(lost_cnt), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_case(2, 0, 0, "fast");
    run_case(2, 3, 3, "lost3");
    run_case(10, 0, 3, "slow");
    run_case(4, 20, 15, "saturate");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule